// File: doc/BRIEF.md
# Chained Four-Stage Sample Trigger

This block watches a stream of wide captured samples and decides when a logic capture should begin. It holds a small set of trigger stages, each with its own compare mask, compare value and a final-stage flag. After a run command only the first stage is live. Every time the live stage matches a valid sample, the next stage becomes live for the following valid sample. The stage carrying the final flag produces a single-cycle trigger pulse when it matches.

A command receiver programs the stages through a simple write port (stage index, register select, data) and issues the run command. The sampling front end presents one sample per `smp_valid` strobe. Alongside the pulse the block reports the index of the stage that fired. Each stage that was passed before the final one shifts the recorded trigger point back by one sample, so downstream logic can use that index as a sample correction.

Top module: `trig_matcher`

## Requirements
- R1: A stage matches a sample when every bit set in its mask has the same value in the sample as in its value register. Bits clear in the mask are not compared, so a zero mask matches any sample.
- R2: Only one stage is live at a time. After a run the live stage is stage 0. A stage that matches without the final flag makes the next stage live from the next valid sample onward. A sample that would satisfy a later stage has no effect while an earlier stage is live.
- R3: Bit 3 of the configuration word is the final flag, and no other configuration bit matters. `trig_pulse` is high for exactly the cycle in which `smp_valid` presents the sample that matches the live final stage. It is driven combinationally in that same cycle.
- R4: While `trig_pulse` is high, `trig_stage` holds the index of the stage that fired. That index equals the number of samples by which the trigger point lies before the firing sample.
- R5: The `run` command clears all progress and makes stage 0 live. A sample offered in the same cycle as `run` is ignored.
- R6: After a pulse, no stage is live, and no further pulse occurs until the next `run`.
- R7: If the last stage (index 3) matches without the final flag, the sequence ends without a pulse. It stays ended until the next `run`, even if configuration changes.
- R8: After reset no stage is live, and all mask, value and flag registers are zero. No pulse occurs before the first `run`.
- R9: Register writes use `cfg_sel` as follows: 0 writes the mask, 1 writes the value, 2 writes the configuration word, and 3 writes nothing. `cfg_stage` selects the stage. A write takes effect from the next cycle.
- R10: Cycles without `smp_valid` neither advance the live stage nor produce a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_stage | input | 2 | Stage addressed by the write |
| cfg_sel | input | 2 | Register select: 0 mask, 1 value, 2 configuration |
| cfg_wdata | input | 32 | Write data |
| run | input | 1 | Clear progress and make stage 0 live |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 32 | Captured sample |
| trig_pulse | output | 1 | Capture-start pulse |
| trig_stage | output | 2 | Index of the live stage (the firing stage during a pulse) |

## Verification
The bench probes partial, single-bit and empty masks. A design that compared unmasked bits, or that inverted the mask sense, would miss or falsely fire on these. It then feeds a later stage's pattern before the earlier stages have matched, and inserts an invalid cycle carrying the final pattern. A design that checked all stages in parallel, or that advanced on invalid cycles, would fire early. It also collides a sample with `run`, repeats the final pattern after a pulse, and runs a chain with no final flag off its end after other configuration bits are set. A design that let the colliding sample count, re-fired, wrapped to stage 0 or decoded the wrong configuration bit would pulse where none is due.

// File: rtl/trig_matcher_pkg.sv
package trig_matcher_pkg;
  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_VALUE = 2'd1,
    SEL_CFG   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/trig_stage_unit.sv
module trig_stage_unit
  import trig_matcher_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 2,
  parameter int STAGE_ID  = 0,
  parameter int FINAL_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_stage,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] smp_data,
  output logic              hit,
  output logic              is_final
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(STAGE_ID);

  logic [DATA_W-1:0] mask_q, mask_n;
  logic [DATA_W-1:0] val_q,  val_n;
  logic              fin_q,  fin_n;
  logic              sel_me;
  reg_sel_e          sel;

  assign sel    = reg_sel_e'(cfg_sel);
  assign sel_me = cfg_we && (cfg_stage == MY_IDX);

  always_comb begin
    mask_n = mask_q;
    val_n  = val_q;
    fin_n  = fin_q;
    if (sel_me) begin
      case (sel)
        SEL_MASK:  mask_n = cfg_wdata;
        SEL_VALUE: val_n  = cfg_wdata;
        SEL_CFG:   fin_n  = cfg_wdata[FINAL_BIT];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      val_q  <= '0;
      fin_q  <= 1'b0;
    end else if (sel_me) begin
      mask_q <= mask_n;
      val_q  <= val_n;
      fin_q  <= fin_n;
    end
  end

  assign hit      = ~|((smp_data ^ val_q) & mask_q);
  assign is_final = fin_q;
endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer #(
  parameter int NUM_STAGES = 4,
  parameter int IDX_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  smp_valid,
  input  logic [NUM_STAGES-1:0] hit_vec,
  input  logic [NUM_STAGES-1:0] fin_vec,
  output logic [IDX_W-1:0]      live_idx,
  output logic                  armed,
  output logic                  fire
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STAGES - 1);

  logic             armed_q, armed_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             step, hit_sel, fin_sel;

  assign hit_sel = hit_vec[idx_q];
  assign fin_sel = fin_vec[idx_q];
  assign step    = smp_valid && armed_q && !run;

  always_comb begin
    armed_n = armed_q;
    idx_n   = idx_q;
    if (run) begin
      armed_n = 1'b1;
      idx_n   = '0;
    end else if (step && hit_sel) begin
      if (fin_sel || (idx_q == LAST_IDX)) begin
        armed_n = 1'b0;
      end else begin
        idx_n = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      armed_q <= armed_n;
      idx_q   <= idx_n;
    end
  end

  assign fire     = step && hit_sel && fin_sel;
  assign live_idx = idx_q;
  assign armed    = armed_q;
endmodule

// File: rtl/trig_matcher.sv
module trig_matcher #(
  parameter int DATA_W     = 32,
  parameter int NUM_STAGES = 4,
  parameter int FINAL_BIT  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [$clog2(NUM_STAGES)-1:0] cfg_stage,
  input  logic [1:0]                    cfg_sel,
  input  logic [DATA_W-1:0]             cfg_wdata,
  input  logic                          run,
  input  logic                          smp_valid,
  input  logic [DATA_W-1:0]             smp_data,
  output logic                          trig_pulse,
  output logic [$clog2(NUM_STAGES)-1:0] trig_stage
);
  localparam int IDX_W = $clog2(NUM_STAGES);

  logic [NUM_STAGES-1:0] hit_vec;
  logic [NUM_STAGES-1:0] fin_vec;
  logic                  armed;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    trig_stage_unit #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .STAGE_ID (g),
      .FINAL_BIT(FINAL_BIT)
    ) i_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_stage(cfg_stage),
      .cfg_sel  (cfg_sel),
      .cfg_wdata(cfg_wdata),
      .smp_data (smp_data),
      .hit      (hit_vec[g]),
      .is_final (fin_vec[g])
    );
  end

  trig_sequencer #(
    .NUM_STAGES(NUM_STAGES),
    .IDX_W     (IDX_W)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .smp_valid(smp_valid),
    .hit_vec  (hit_vec),
    .fin_vec  (fin_vec),
    .live_idx (trig_stage),
    .armed    (armed),
    .fire     (trig_pulse)
  );
endmodule

// File: rtl/trig_matcher_chk.sv
module trig_matcher_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             smp_valid,
  input logic             trig_pulse,
  input logic [IDX_W-1:0] trig_stage,
  input logic             armed
);
  assert_pulse_needs_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> smp_valid);

  assert_pulse_needs_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> armed);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  assert_idle_after_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && !run) |=> !armed);

  assert_run_blocks_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !trig_pulse);

  assert_run_arms_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (armed && (trig_stage == '0)));

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !run) |=> ($stable(trig_stage) && $stable(armed)));
endmodule

bind trig_matcher trig_matcher_chk #(.IDX_W($clog2(NUM_STAGES))) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .smp_valid (smp_valid),
  .trig_pulse(trig_pulse),
  .trig_stage(trig_stage),
  .armed     (armed)
);

// File: tb/test_trig_matcher.sv
module test_trig_matcher;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_stage;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        run;
  logic        smp_valid;
  logic [31:0] smp_data;
  logic        trig_pulse;
  logic [1:0]  trig_stage;

  int n_checks = 0;
  int n_bad    = 0;

  trig_matcher i_trig_matcher (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stage(cfg_stage),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .run(run),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .trig_pulse(trig_pulse), .trig_stage(trig_stage)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // mask, value, sample, expected pulse
  typedef struct packed {
    logic [31:0] mask;
    logic [31:0] val;
    logic [31:0] data;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678, 1'b1},
    '{32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5679, 1'b0},
    '{32'h0000_FF00, 32'h0000_AB00, 32'hFFFF_ABFF, 1'b1},
    '{32'h0000_FF00, 32'h0000_AB00, 32'h0000_AA00, 1'b0},
    '{32'h8000_0001, 32'h8000_0000, 32'h8000_0000, 1'b1},
    '{32'h8000_0001, 32'h8000_0000, 32'h8000_0001, 1'b0},
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
    '{32'hF0F0_F0F0, 32'hA0B0_C0D0, 32'hAFBF_CFDF, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus, driven at the falling edge
  task automatic idle_inputs();
    cfg_we = 1'b0; cfg_stage = '0; cfg_sel = '0; cfg_wdata = '0;
    run = 1'b0; smp_valid = 1'b0; smp_data = '0;
  endtask

  task automatic wr(input logic [1:0] stg, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    idle_inputs();
    cfg_we = 1'b1; cfg_stage = stg; cfg_sel = sel; cfg_wdata = d;
  endtask

  task automatic do_run();
    @(negedge clk);
    idle_inputs();
    run = 1'b1;
  endtask

  // present a sample, then check the combinational pulse in that cycle
  task automatic smp(input logic v, input logic [31:0] d, input logic exp_p,
                     input string req);
    @(negedge clk);
    idle_inputs();
    smp_valid = v; smp_data = d;
    #1;
    check(req, {31'b0, trig_pulse}, {31'b0, exp_p});
  endtask

  task automatic prog(input logic [1:0] stg, input logic [31:0] m,
                      input logic [31:0] v, input logic [31:0] c);
    wr(stg, 2'd0, m);
    wr(stg, 2'd1, v);
    wr(stg, 2'd2, c);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: reset state, nothing live, zero registers (zero mask would match)
    smp(1'b1, 32'h0, 1'b0, "R8 no pulse after reset");
    check("R8 stage index after reset", {30'b0, trig_stage}, 32'h0);
    prog(2'd0, 32'h0, 32'h0, 32'h8);
    smp(1'b1, 32'h5, 1'b0, "R8 no pulse before run");

    // R1 / R9: compare vectors on stage 0 with final flag
    for (int i = 0; i < 8; i++) begin
      prog(2'd0, VECS[i].mask, VECS[i].val, 32'h8);
      do_run();
      smp(1'b1, VECS[i].data, VECS[i].exp, $sformatf("R1 vector %0d", i));
      if (VECS[i].exp)
        check("R4 stage index single", {30'b0, trig_stage}, 32'h0);
    end

    // R9: select 3 writes nothing; mask stays all ones, value stays 0x55
    prog(2'd0, 32'hFFFF_FFFF, 32'h55, 32'h8);
    wr(2'd0, 2'd3, 32'h0);
    do_run();
    smp(1'b1, 32'h0, 1'b0, "R9 select 3 ignored");
    smp(1'b1, 32'h55, 1'b1, "R9 register intact");

    // R2 / R4 / R10 / R6: three-stage chain 01 -> 02 -> 03 (final at stage 2)
    prog(2'd0, 32'hFF, 32'h01, 32'h0);
    prog(2'd1, 32'hFF, 32'h02, 32'hFFFF_FFF7);
    prog(2'd2, 32'hFF, 32'h03, 32'h8);
    prog(2'd3, 32'h0,  32'h0,  32'h8);
    do_run();
    smp(1'b1, 32'h03, 1'b0, "R2 later pattern early");
    smp(1'b1, 32'h02, 1'b0, "R2 stage1 pattern early");
    smp(1'b1, 32'h01, 1'b0, "R3 non-final stage no pulse");
    smp(1'b1, 32'h01, 1'b0, "R2 stage0 pattern repeated");
    smp(1'b1, 32'h02, 1'b0, "R3 other cfg bits not final");
    smp(1'b0, 32'h03, 1'b0, "R10 invalid cycle");
    smp(1'b0, 32'h03, 1'b0, "R10 invalid cycle again");
    smp(1'b1, 32'h03, 1'b1, "R3 final stage pulse");
    check("R4 stage index chain", {30'b0, trig_stage}, 32'h2);
    smp(1'b1, 32'h03, 1'b0, "R6 no second pulse");
    smp(1'b1, 32'h00, 1'b0, "R6 idle after pulse");

    // R5: run clears progress, colliding sample ignored
    do_run();
    smp(1'b1, 32'h01, 1'b0, "R5 stage0 match");
    @(negedge clk);
    idle_inputs();
    run = 1'b1; smp_valid = 1'b1; smp_data = 32'h02;
    #1;
    check("R5 no pulse with run", {31'b0, trig_pulse}, 32'h0);
    smp(1'b1, 32'h02, 1'b0, "R5 progress cleared");
    smp(1'b1, 32'h03, 1'b0, "R5 progress cleared 2");
    smp(1'b1, 32'h01, 1'b0, "R5 restart stage0");
    smp(1'b1, 32'h02, 1'b0, "R5 restart stage1");
    smp(1'b1, 32'h03, 1'b1, "R5 restart fires");

    // R7: chain with no final flag runs off stage 3
    for (int s = 0; s < 4; s++) prog(2'(s), 32'h0, 32'h0, 32'hFFFF_FFF7);
    do_run();
    for (int k = 0; k < 5; k++) smp(1'b1, 32'hDEAD_0000 + 32'(k), 1'b0, "R7 no final");
    wr(2'd3, 2'd2, 32'h8);
    smp(1'b1, 32'h0, 1'b0, "R7 ended until run");
    do_run();
    smp(1'b1, 32'h1, 1'b0, "R2 pass stage0");
    smp(1'b1, 32'h2, 1'b0, "R2 pass stage1");
    smp(1'b1, 32'h3, 1'b0, "R2 pass stage2");
    smp(1'b1, 32'h4, 1'b1, "R3 stage3 final");
    check("R4 stage index last", {30'b0, trig_stage}, 32'h3);

    // R8: asynchronous reset mid-sequence clears everything
    do_run();
    smp(1'b1, 32'h1, 1'b0, "R8 pre-reset progress");
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    smp(1'b1, 32'h0, 1'b0, "R8 reset clears live stage");

    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule